// File: doc/BRIEF.md
# Event Status Interrupt and DMA Request Aggregator

This block keeps a 16-bit word of event flags and a narrow enable mask. From them it drives one level-sensitive interrupt line and two DMA request lines, one for the receive side and one for the transmit side. Event sources elsewhere in the controller raise or drop individual flags through per-bit set and clear pulse inputs. A register-style access port gives software the mask, the flags, a DMA-control word, a test word and an interrupt-vector word. The vector word names the lowest pending enabled event and acknowledges it.

A static revision strap picks one of two behaviours. Legacy mode has a 5-bit mask and read-only flags, and it offers the vector word. Newer mode has a 6-bit mask, lets software write ones to clear some flags, and can force the low flags through the test word. All outputs come combinationally from registered state. Any access or pulse therefore shows at the pins one cycle after it is applied.

Register select encoding on `acc_sel`: 0 mask, 1 status, 2 vector, 3 DMA control, 4 test; other codes read as zero and ignore writes.

Top module: `irq_event_agg`

## Requirements
- R1: `irq` is 1 exactly when some status bit in positions 5..0 is 1 together with the matching mask bit.
- R2: `rx_dreq` equals status bit 3 while DMA-control bit 15 is 1, else 0; `tx_dreq` equals status bit 4 while DMA-control bit 7 is 1, else 0.
- R3: A DMA-control write (select 3) stores only data bits 15 and 7, which read back in the same positions. A 1 in bit 15 clears mask bit 3, and a 1 in bit 7 clears mask bit 4.
- R4: A mask write (select 0) keeps data bits 4..0 in legacy mode (strap 1) and bits 5..0 in newer mode (strap 0). It reads back zero-extended.
- R5: In legacy mode a vector read (select 2) returns 1 plus the position of the lowest set bit of status[5..0] AND mask, or 0 if there is none, and clears that status bit at the end of the access. In newer mode it returns 0 and changes nothing.
- R6: In newer mode a status write (select 1) clears the status bits set in the data AND 0x0027. In legacy mode a status write changes nothing.
- R7: In newer mode a test write (select 4) with data bit 11 set makes status bits 5..0 all 1. In legacy mode it changes nothing.
- R8: A status read returns the stored status with bit 12 replaced by the live `bus_busy` input.
- R9: A set pulse on a bit wins over a clear of that bit in the same cycle, whether the clear comes from a clear pulse, a status write or a vector read.
- R10: After reset the status, mask and DMA enables are zero and all three outputs are low. Every change is visible at the outputs one clock after the cycle that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| legacy_mode | input | 1 | Revision strap: 1 legacy, 0 newer; static while out of reset |
| evt_set | input | 16 | Per-bit status set pulses |
| evt_clr | input | 16 | Per-bit status clear pulses |
| bus_busy | input | 1 | Live busy indication shown in status bit 12 on reads |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe (side effects only for the vector word) |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data for the selected register, combinational |
| irq | output | 1 | Level interrupt |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
The assertions take it for granted that the revision strap holds still outside reset and that at most one of read and write is active in a cycle. A vector-read clear is only checked when no set pulse hits the same bit. The stimulus changes the strap only while reset is asserted and issues one access per step. It applies set and clear pulses together only in the steps that target the set-wins rule.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int SEL_W = 3;
   typedef enum logic [SEL_W-1:0] {
      SEL_MASK = 3'd0,
      SEL_STAT = 3'd1,
      SEL_VEC  = 3'd2,
      SEL_DMAC = 3'd3,
      SEL_TEST = 3'd4
   } agg_sel_e;
endpackage

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
   parameter int STAT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set_i,
   input  logic [STAT_W-1:0] clr_i,
   output logic [STAT_W-1:0] stat_o
);
   logic [STAT_W-1:0] stat_q;

   for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)          stat_q[b] <= 1'b0;
         else if (set_i[b])   stat_q[b] <= 1'b1;
         else if (clr_i[b])   stat_q[b] <= 1'b0;
      end
   end

   assign stat_o = stat_q;
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl #(
   parameter int MASK_W        = 6,
   parameter int LEGACY_MASK_W = 5,
   parameter int DATA_W        = 16,
   parameter int RX_RDY_BIT    = 3,
   parameter int TX_RDY_BIT    = 4,
   parameter int RX_DMA_BIT    = 15,
   parameter int TX_DMA_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              legacy,
   input  logic              mask_we,
   input  logic              dmac_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [MASK_W-1:0] mask_o,
   output logic              rx_en_o,
   output logic              tx_en_o
);
   localparam logic [MASK_W-1:0] KEEP_NEW = {MASK_W{1'b1}};
   localparam logic [MASK_W-1:0] KEEP_OLD = MASK_W'((1 << LEGACY_MASK_W) - 1);

   logic [MASK_W-1:0] mask_q, mask_d;
   logic              rx_en_q, tx_en_q;

   always_comb begin
      mask_d = mask_q;
      if (mask_we)
         mask_d = wdata[MASK_W-1:0] & (legacy ? KEEP_OLD : KEEP_NEW);
      if (dmac_we) begin
         if (wdata[RX_DMA_BIT]) mask_d[RX_RDY_BIT] = 1'b0;
         if (wdata[TX_DMA_BIT]) mask_d[TX_RDY_BIT] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         rx_en_q <= 1'b0;
         tx_en_q <= 1'b0;
      end else begin
         mask_q <= mask_d;
         if (dmac_we) begin
            rx_en_q <= wdata[RX_DMA_BIT];
            tx_en_q <= wdata[TX_DMA_BIT];
         end
      end
   end

   assign mask_o  = mask_q;
   assign rx_en_o = rx_en_q;
   assign tx_en_o = tx_en_q;
endmodule

// File: rtl/irq_agg_lowest.sv
module irq_agg_lowest #(
   parameter int W     = 6,
   parameter int IDX_W = $clog2(W + 1)
) (
   input  logic [W-1:0]     pend_i,
   output logic [IDX_W-1:0] idx_o,
   output logic [W-1:0]     onehot_o
);
   always_comb begin
      idx_o = '0;
      for (int i = W - 1; i >= 0; i--)
         if (pend_i[i]) idx_o = IDX_W'(i + 1);
   end

   assign onehot_o = pend_i & (~pend_i + W'(1));
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
   import irq_agg_pkg::*;
#(
   parameter int              STAT_W         = 16,
   parameter int              MASK_W         = 6,
   parameter int              LEGACY_MASK_W  = 5,
   parameter int              RX_RDY_BIT     = 3,
   parameter int              TX_RDY_BIT     = 4,
   parameter int              BUSY_BIT       = 12,
   parameter int              RX_DMA_BIT     = 15,
   parameter int              TX_DMA_BIT     = 7,
   parameter int              TEST_FORCE_BIT = 11,
   parameter logic [STAT_W-1:0] SW_CLR_BITS  = 16'h0027
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              legacy_mode,
   input  logic [STAT_W-1:0] evt_set,
   input  logic [STAT_W-1:0] evt_clr,
   input  logic              bus_busy,
   input  logic              acc_wr,
   input  logic              acc_rd,
   input  logic [SEL_W-1:0]  acc_sel,
   input  logic [STAT_W-1:0] acc_wdata,
   output logic [STAT_W-1:0] acc_rdata,
   output logic              irq,
   output logic              rx_dreq,
   output logic              tx_dreq
);
   localparam int VEC_W = $clog2(MASK_W + 1);

   if (MASK_W > STAT_W)              begin : g_chk_mask  $error("mask wider than status"); end
   if (LEGACY_MASK_W > MASK_W)       begin : g_chk_leg   $error("legacy mask wider than mask"); end
   if (RX_RDY_BIT >= MASK_W)         begin : g_chk_rx    $error("rx ready bit outside mask"); end
   if (TX_RDY_BIT >= MASK_W)         begin : g_chk_tx    $error("tx ready bit outside mask"); end
   if (BUSY_BIT >= STAT_W)           begin : g_chk_busy  $error("busy bit outside status"); end
   if (RX_DMA_BIT >= STAT_W || TX_DMA_BIT >= STAT_W || TEST_FORCE_BIT >= STAT_W)
                                     begin : g_chk_dat   $error("control bit outside data"); end

   logic [STAT_W-1:0] stat_q;
   logic [MASK_W-1:0] mask_q;
   logic              rx_en, tx_en;
   logic [MASK_W-1:0] pend, pend_low;
   logic [VEC_W-1:0]  vec_idx;
   logic              wr_mask, wr_stat, wr_dmac, wr_test, rd_vec;
   logic [STAT_W-1:0] set_all, clr_all, stat_view;

   assign wr_mask = acc_wr && (acc_sel == SEL_MASK);
   assign wr_stat = acc_wr && (acc_sel == SEL_STAT) && !legacy_mode;
   assign wr_dmac = acc_wr && (acc_sel == SEL_DMAC);
   assign wr_test = acc_wr && (acc_sel == SEL_TEST) && !legacy_mode;
   assign rd_vec  = acc_rd && (acc_sel == SEL_VEC)  && legacy_mode;

   assign pend = stat_q[MASK_W-1:0] & mask_q;

   irq_agg_lowest #(.W(MASK_W), .IDX_W(VEC_W)) u_low (
      .pend_i   (pend),
      .idx_o    (vec_idx),
      .onehot_o (pend_low)
   );

   always_comb begin
      set_all = evt_set;
      if (wr_test && acc_wdata[TEST_FORCE_BIT])
         set_all[MASK_W-1:0] = {MASK_W{1'b1}};
      clr_all = evt_clr;
      if (wr_stat) clr_all = clr_all | (acc_wdata & SW_CLR_BITS);
      if (rd_vec)  clr_all = clr_all | STAT_W'(pend_low);
   end

   irq_agg_status #(.STAT_W(STAT_W)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_all),
      .clr_i  (clr_all),
      .stat_o (stat_q)
   );

   irq_agg_ctrl #(
      .MASK_W(MASK_W), .LEGACY_MASK_W(LEGACY_MASK_W), .DATA_W(STAT_W),
      .RX_RDY_BIT(RX_RDY_BIT), .TX_RDY_BIT(TX_RDY_BIT),
      .RX_DMA_BIT(RX_DMA_BIT), .TX_DMA_BIT(TX_DMA_BIT)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .legacy  (legacy_mode),
      .mask_we (wr_mask),
      .dmac_we (wr_dmac),
      .wdata   (acc_wdata),
      .mask_o  (mask_q),
      .rx_en_o (rx_en),
      .tx_en_o (tx_en)
   );

   always_comb begin
      stat_view           = stat_q;
      stat_view[BUSY_BIT] = bus_busy;
   end

   always_comb begin
      acc_rdata = '0;
      case (acc_sel)
         SEL_MASK: acc_rdata = STAT_W'(mask_q);
         SEL_STAT: acc_rdata = stat_view;
         SEL_VEC:  acc_rdata = legacy_mode ? STAT_W'(vec_idx) : '0;
         SEL_DMAC: begin
            acc_rdata[RX_DMA_BIT] = rx_en;
            acc_rdata[TX_DMA_BIT] = tx_en;
         end
         default:  acc_rdata = '0;
      endcase
   end

   assign irq     = |pend;
   assign rx_dreq = rx_en & stat_q[RX_RDY_BIT];
   assign tx_dreq = tx_en & stat_q[TX_RDY_BIT];
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
   import irq_agg_pkg::*;
#(
   parameter int STAT_W         = 16,
   parameter int MASK_W         = 6,
   parameter int LEGACY_MASK_W  = 5,
   parameter int RX_RDY_BIT     = 3,
   parameter int TX_RDY_BIT     = 4,
   parameter int RX_DMA_BIT     = 15,
   parameter int TX_DMA_BIT     = 7,
   parameter int TEST_FORCE_BIT = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              legacy_mode,
   input logic [STAT_W-1:0] evt_set,
   input logic [STAT_W-1:0] evt_clr,
   input logic              acc_wr,
   input logic              acc_rd,
   input logic [SEL_W-1:0]  acc_sel,
   input logic [STAT_W-1:0] acc_wdata,
   input logic [STAT_W-1:0] acc_rdata,
   input logic              irq,
   input logic              rx_dreq,
   input logic              tx_dreq,
   input logic [STAT_W-1:0] stat_q,
   input logic [MASK_W-1:0] mask_q
);
   // R1: vector encoder and interrupt OR agree on whether anything is pending
   assert_vec_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && acc_sel == SEL_VEC && legacy_mode) |-> ((acc_rdata != '0) == irq));

   // R2: DMA requests only with the matching ready flag
   assert_rx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dreq |-> stat_q[RX_RDY_BIT]);
   assert_tx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dreq |-> stat_q[TX_RDY_BIT]);

   // R3: enabling receive DMA drops the receive-ready interrupt enable
   assert_dmac_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_sel == SEL_DMAC && acc_wdata[RX_DMA_BIT]) |=> !mask_q[RX_RDY_BIT]);

   // R4: legacy mask write keeps only the narrow field
   assert_legacy_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_sel == SEL_MASK && legacy_mode) |=> ((mask_q >> LEGACY_MASK_W) == '0));

   // R5: vector read of event 1 acknowledges status bit 0
   assert_vec_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && acc_sel == SEL_VEC && legacy_mode && acc_rdata == STAT_W'(1) && !evt_set[0])
      |=> !stat_q[0]);

   // R6: legacy status write leaves status untouched
   assert_stat_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (legacy_mode && acc_wr && acc_sel == SEL_STAT && evt_set == '0 && evt_clr == '0)
      |=> (stat_q == $past(stat_q)));

   // R7: newer-mode test force sets the low flags
   assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!legacy_mode && acc_wr && acc_sel == SEL_TEST && acc_wdata[TEST_FORCE_BIT])
      |=> (&stat_q[MASK_W-1:0]));

   // R9: set pulses always land
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set != '0) |=> ((stat_q & $past(evt_set)) == $past(evt_set)));
endmodule

bind irq_event_agg irq_agg_chk #(
   .STAT_W(STAT_W), .MASK_W(MASK_W), .LEGACY_MASK_W(LEGACY_MASK_W),
   .RX_RDY_BIT(RX_RDY_BIT), .TX_RDY_BIT(TX_RDY_BIT),
   .RX_DMA_BIT(RX_DMA_BIT), .TX_DMA_BIT(TX_DMA_BIT), .TEST_FORCE_BIT(TEST_FORCE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
   .evt_set(evt_set), .evt_clr(evt_clr),
   .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_sel(acc_sel),
   .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
   .irq(irq), .rx_dreq(rx_dreq), .tx_dreq(tx_dreq),
   .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/sim_irq_event_agg.sv
`timescale 1ns/1ps
module sim_irq_event_agg;
   localparam logic [2:0] S_MASK = 3'd0, S_STAT = 3'd1, S_VEC = 3'd2,
                          S_DMAC = 3'd3, S_TEST = 3'd4;

   typedef struct packed {
      logic        rd;
      logic        wr;
      logic [2:0]  sel;
      logic [15:0] wd;
      logic [15:0] set;
      logic [15:0] clr;
      logic        busy;
      logic        ck;
      logic [15:0] exp_rd;
      logic [2:0]  exp_out;   // {irq, rx_dreq, tx_dreq}
      logic [3:0]  req;
   } vec_t;

   localparam int N_NEW = 26;
   // newer mode (strap 0), starting from reset
   localparam vec_t TBL [N_NEW] = '{
      '{1,0,S_MASK,16'h0000,16'h0000,16'h0000,0,1,16'h0000,3'b000,4'd10}, // R10
      '{0,1,S_MASK,16'hFFFF,16'h0000,16'h0000,0,0,16'h0000,3'b000,4'd4},  // R4
      '{1,0,S_MASK,16'h0000,16'h0000,16'h0000,0,1,16'h003F,3'b000,4'd4},  // R4
      '{0,0,S_MASK,16'h0000,16'h0008,16'h0000,0,0,16'h0000,3'b100,4'd1},  // R1
      '{0,1,S_DMAC,16'hFFFF,16'h0000,16'h0000,0,0,16'h0000,3'b010,4'd3},  // R3
      '{1,0,S_DMAC,16'h0000,16'h0000,16'h0000,0,1,16'h8080,3'b010,4'd3},  // R3
      '{1,0,S_MASK,16'h0000,16'h0000,16'h0000,0,1,16'h0027,3'b010,4'd3},  // R3
      '{0,0,S_MASK,16'h0000,16'h0010,16'h0000,0,0,16'h0000,3'b011,4'd2},  // R2
      '{0,0,S_MASK,16'h0000,16'h0000,16'h0008,0,0,16'h0000,3'b001,4'd2},  // R2
      '{0,0,S_MASK,16'h0000,16'h0001,16'h0000,0,0,16'h0000,3'b101,4'd1},  // R1
      '{0,1,S_STAT,16'hFFFF,16'h0000,16'h0000,0,0,16'h0000,3'b001,4'd6},  // R6
      '{0,1,S_STAT,16'h0001,16'h0001,16'h0000,0,0,16'h0000,3'b101,4'd9},  // R9
      '{1,0,S_STAT,16'h0000,16'h0000,16'h0000,1,1,16'h1011,3'b101,4'd8},  // R8
      '{1,0,S_STAT,16'h0000,16'h0000,16'h0000,0,1,16'h0011,3'b101,4'd8},  // R8
      '{1,0,S_STAT,16'h0000,16'h1000,16'h0000,0,1,16'h0011,3'b101,4'd8},  // R8
      '{1,0,S_STAT,16'h0000,16'h0000,16'h0000,0,1,16'h0011,3'b101,4'd8},  // R8
      '{1,0,S_VEC ,16'h0000,16'h0000,16'h0000,0,1,16'h0000,3'b101,4'd5},  // R5
      '{1,0,S_STAT,16'h0000,16'h0000,16'h0000,0,1,16'h0011,3'b101,4'd5},  // R5
      '{0,1,S_TEST,16'h0800,16'h0000,16'h0000,0,0,16'h0000,3'b111,4'd7},  // R7
      '{1,0,S_STAT,16'h0000,16'h0000,16'h0000,1,1,16'h103F,3'b111,4'd7},  // R7
      '{0,1,S_DMAC,16'h0000,16'h0000,16'h0000,0,0,16'h0000,3'b100,4'd2},  // R2
      '{0,1,S_MASK,16'h0000,16'h0000,16'h0000,0,0,16'h0000,3'b000,4'd1},  // R1
      '{0,1,S_STAT,16'hFFFF,16'h0000,16'h0000,0,0,16'h0000,3'b000,4'd6},  // R6
      '{1,0,S_STAT,16'h0000,16'h0000,16'h0000,0,1,16'h0018,3'b000,4'd6},  // R6
      '{0,0,S_MASK,16'h0000,16'h0001,16'h0001,0,0,16'h0000,3'b000,4'd9},  // R9
      '{1,0,S_STAT,16'h0000,16'h0000,16'h0000,0,1,16'h0019,3'b000,4'd9}   // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        legacy_mode = 1'b0;
   logic [15:0] evt_set = '0, evt_clr = '0, acc_wdata = '0;
   logic        bus_busy = 1'b0, acc_wr = 1'b0, acc_rd = 1'b0;
   logic [2:0]  acc_sel = '0;
   logic [15:0] acc_rdata;
   logic        irq, rx_dreq, tx_dreq;
   int          n_chk = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   irq_event_agg u0 (
      .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode),
      .evt_set(evt_set), .evt_clr(evt_clr), .bus_busy(bus_busy),
      .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_sel(acc_sel),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .irq(irq), .rx_dreq(rx_dreq), .tx_dreq(tx_dreq)
   );

   task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the following negedge
   task automatic step(input vec_t v);
      acc_rd = v.rd; acc_wr = v.wr; acc_sel = v.sel; acc_wdata = v.wd;
      evt_set = v.set; evt_clr = v.clr; bus_busy = v.busy;
      #1;
      if (v.ck) chk(int'(v.req), "read data", acc_rdata, v.exp_rd);
      @(posedge clk);
      @(negedge clk);
      acc_rd = 0; acc_wr = 0; evt_set = '0; evt_clr = '0; bus_busy = 0;
      chk(int'(v.req), "irq/rx/tx", {13'd0, irq, rx_dreq, tx_dreq}, {13'd0, v.exp_out});
   endtask

   task automatic do_reset(input logic leg);
      @(negedge clk);
      rst_n = 0; legacy_mode = leg;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   initial begin
      do_reset(1'b0);
      // R10 reset state
      chk(10, "reset outputs", {13'd0, irq, rx_dreq, tx_dreq}, 16'h0);
      acc_sel = S_STAT; #1;
      chk(10, "reset status", acc_rdata, 16'h0);
      @(negedge clk);

      for (int i = 0; i < N_NEW; i++) step(TBL[i]);

      // R10 reset in the middle of activity
      do_reset(1'b1);
      chk(10, "re-reset outputs", {13'd0, irq, rx_dreq, tx_dreq}, 16'h0);

      // legacy mode directed tests
      step('{0,1,S_MASK,16'hFFFF,16'h0000,16'h0000,0,0,16'h0000,3'b000,4'd4}); // R4
      step('{1,0,S_MASK,16'h0000,16'h0000,16'h0000,0,1,16'h001F,3'b000,4'd4}); // R4
      step('{0,0,S_MASK,16'h0000,16'h0034,16'h0000,0,0,16'h0000,3'b100,4'd1}); // R1
      step('{1,0,S_VEC ,16'h0000,16'h0000,16'h0000,0,1,16'h0003,3'b100,4'd5}); // R5
      step('{1,0,S_VEC ,16'h0000,16'h0000,16'h0000,0,1,16'h0005,3'b000,4'd5}); // R5
      step('{1,0,S_VEC ,16'h0000,16'h0000,16'h0000,0,1,16'h0000,3'b000,4'd5}); // R5
      step('{0,1,S_STAT,16'hFFFF,16'h0000,16'h0000,0,0,16'h0000,3'b000,4'd6}); // R6
      step('{1,0,S_STAT,16'h0000,16'h0000,16'h0000,0,1,16'h0020,3'b000,4'd6}); // R6
      step('{0,1,S_TEST,16'h0800,16'h0000,16'h0000,0,0,16'h0000,3'b000,4'd7}); // R7
      step('{1,0,S_STAT,16'h0000,16'h0000,16'h0000,0,1,16'h0020,3'b000,4'd7}); // R7
      step('{1,0,S_VEC ,16'h0000,16'h0002,16'h0000,0,1,16'h0000,3'b100,4'd9}); // R9
      step('{1,0,S_VEC ,16'h0000,16'h0002,16'h0000,0,1,16'h0002,3'b100,4'd9}); // R9
      step('{1,0,S_STAT,16'h0000,16'h0000,16'h0000,0,1,16'h0022,3'b100,4'd9}); // R9

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule